// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. A single counter does two jobs. It times the fixed first ramp, during which the integrator charges from the unknown input. It then measures the second ramp, during which the integrator discharges toward zero through the negative reference. The analog parts sit outside the block: the integrator, the zero-crossing comparator, the auto-zero switch and the input selector. The block drives the auto-zero switch and the selector, and it reads one comparator bit that is high while the integrator output is away from zero.

A start pulse given while the block is idle begins a conversion. The block first holds the auto-zero switch closed for a set number of clocks. It then connects the unknown input and waits until the comparator reports a non-zero integrator output. From that point the counter runs from zero. When it overflows back to zero, the selector moves to the reference and the counter keeps running without a reload. The value the counter holds when the comparator returns low is the result, marked by a one-cycle done strobe. A larger input charges the integrator higher, so the second ramp lasts longer and the conversion takes more time. If the discharge ramp runs for a full counter period, the conversion stops with an overrange flag and a result of all ones.

Top module: `dslope_seq`

## Requirements
- R1: After reset the block is idle: az_on, ref_sel, busy, done and overrange are 0 and result is 0.
- R2: start is acted on only while busy is 0. A start pulse during a conversion changes neither that conversion's timing nor its result, and it does not trigger a second conversion.
- R3: After an accepted start, az_on is 1 for exactly ZERO_CYC consecutive clocks while ref_sel is 0. az_on and ref_sel are never 1 together.
- R4: After auto-zero the unknown input is connected (az_on=0, ref_sel=0). Counting begins only on the first clock where cmp_away is 1. While cmp_away stays 0 the block remains busy, ref_sel stays 0 and no done occurs.
- R5: The first ramp lasts exactly 2^CNT_W clocks from the clock on which counting begins. After that, ref_sel goes to 1 (1 = negative reference, 0 = unknown input).
- R6: The counter is not reloaded at overflow. The result is the number of clocks spent in the second ramp before the clock on which cmp_away is sampled 0. done rises on the edge at which ref_sel falls.
- R7: done is high for one clock per conversion, and result and overrange keep their values until the next done.
- R8: If cmp_away is still 1 when the second-ramp count reaches all ones, the conversion ends with overrange=1 and result all ones. A later in-range conversion reports overrange=0.
- R9: Conversion time, from start to done, grows with input magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, honoured only when idle |
| cmp_away | input | 1 | Comparator: 1 while the integrator output is away from zero |
| az_on | output | 1 | Closes the auto-zero switch |
| ref_sel | output | 1 | Integrator input select: 1 negative reference, 0 unknown input |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle strobe: result and overrange updated |
| overrange | output | 1 | Last conversion timed out in the second ramp |
| result | output | CNT_W | Last conversion count |

## Verification
Most internal faults show up in the start-to-done latency, and only at the end of a conversion. A wrong auto-zero length, a first ramp that is not exactly one counter period, or a counter reloaded at overflow each shift done by a fixed number of clocks, some 1,000 clocks after start. The bench therefore checks the exact latency and counts the clocks during which az_on and ref_sel are high. A stuck sequencing state appears sooner: when the comparator never trips, the block must remain busy with the selector on the input, so a bad state shows as a wrong ref_sel or a spurious done within a few clocks.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ZERO,
      ST_ARM,
      ST_UP,
      ST_DOWN
   } seq_st_t;
endpackage

// File: rtl/dslope_zero_timer.sv
module dslope_zero_timer #(
   parameter int ZERO_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);
   localparam int TW = (ZERO_CYC > 1) ? $clog2(ZERO_CYC) : 1;

   generate
      if (ZERO_CYC == 1) begin : g_single
         assign last = run;
      end else begin : g_count
         logic [TW-1:0] tcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   tcnt <= '0;
            else if (!run) tcnt <= '0;
            else          tcnt <= tcnt + TW'(1);
         end
         assign last = run && (tcnt == TW'(ZERO_CYC - 1));
      end
   endgenerate
endmodule

// File: rtl/dslope_counter.sv
module dslope_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] q,
   output logic             at_max
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (inc) q <= q + CNT_W'(1);
   end
   assign at_max = &q;
endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
   import dslope_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cmp_away,
   input  logic             zero_last,
   input  logic             cnt_max,
   input  logic [CNT_W-1:0] cnt_q,
   output seq_st_t          st,
   output logic             cnt_clr,
   output logic             cnt_inc,
   output logic             done,
   output logic             overrange,
   output logic [CNT_W-1:0] result
);
   seq_st_t st_nx;
   logic    finish_ok, finish_ovr;

   assign finish_ok  = (st == ST_DOWN) && !cmp_away;
   assign finish_ovr = (st == ST_DOWN) && cmp_away && cnt_max;

   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE: if (start)     st_nx = ST_ZERO;
         ST_ZERO: if (zero_last) st_nx = ST_ARM;
         ST_ARM:  if (cmp_away)  st_nx = ST_UP;
         ST_UP:   if (cnt_max)   st_nx = ST_DOWN;
         ST_DOWN: if (finish_ok || finish_ovr) st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   assign cnt_clr = (st != ST_UP) && (st != ST_DOWN);
   assign cnt_inc = (st == ST_UP) || ((st == ST_DOWN) && cmp_away && !cnt_max);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         done      <= 1'b0;
         overrange <= 1'b0;
         result    <= '0;
      end else begin
         st   <= st_nx;
         done <= finish_ok || finish_ovr;
         if (finish_ok) begin
            result    <= cnt_q;
            overrange <= 1'b0;
         end else if (finish_ovr) begin
            result    <= '1;
            overrange <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
   import dslope_pkg::*;
#(
   parameter int CNT_W    = 10,
   parameter int ZERO_CYC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cmp_away,
   output logic             az_on,
   output logic             ref_sel,
   output logic             busy,
   output logic             done,
   output logic             overrange,
   output logic [CNT_W-1:0] result
);
   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
         $error("dslope_seq: CNT_W must lie in 2..24");
      end
      if (ZERO_CYC < 1) begin : g_bad_zero
         $error("dslope_seq: ZERO_CYC must be at least 1");
      end
   endgenerate

   seq_st_t          st;
   logic             zero_last, cnt_clr, cnt_inc, cnt_max;
   logic [CNT_W-1:0] cnt_q;

   dslope_zero_timer #(.ZERO_CYC(ZERO_CYC)) u_zero (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st == ST_ZERO),
      .last  (zero_last)
   );

   dslope_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cnt_clr),
      .inc    (cnt_inc),
      .q      (cnt_q),
      .at_max (cnt_max)
   );

   dslope_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cmp_away  (cmp_away),
      .zero_last (zero_last),
      .cnt_max   (cnt_max),
      .cnt_q     (cnt_q),
      .st        (st),
      .cnt_clr   (cnt_clr),
      .cnt_inc   (cnt_inc),
      .done      (done),
      .overrange (overrange),
      .result    (result)
   );

   assign az_on   = (st == ST_ZERO);
   assign ref_sel = (st == ST_DOWN);
   assign busy    = (st != ST_IDLE);
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             az_on,
   input logic             ref_sel,
   input logic             busy,
   input logic             done,
   input logic             overrange,
   input logic [CNT_W-1:0] result
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!az_on && !ref_sel));

   p_switch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(az_on && ref_sel));

   p_done_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_sel) |-> done);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(overrange)));

   p_ovr_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && overrange) |-> (&result));
endmodule

bind dslope_seq dslope_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .az_on     (az_on),
   .ref_sel   (ref_sel),
   .busy      (busy),
   .done      (done),
   .overrange (overrange),
   .result    (result)
);

// File: tb/sim_dslope_seq.sv
module sim_dslope_seq;
   localparam int CLK_PERIOD = 10;
   localparam int CW   = 10;
   localparam int ZC   = 16;
   localparam int MAXV = (1 << CW) - 1;
   localparam int VREF = 2048;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          cmp_away;
   logic          az_on, ref_sel, busy, done, overrange;
   logic [CW-1:0] result;

   int checks = 0;
   int failures = 0;
   int vin = 0;
   int integ = 0;
   int az_cnt = 0, sel_cnt = 0, done_cnt = 0;
   int cycles = 0;
   int lat_small = 0, lat_big = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dslope_seq #(.CNT_W(CW), .ZERO_CYC(ZC)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_away(cmp_away),
      .az_on(az_on), .ref_sel(ref_sel), .busy(busy), .done(done),
      .overrange(overrange), .result(result)
   );

   // behavioural integrator and comparator
   assign cmp_away = (integ > 0);
   always @(posedge clk) begin
      if (az_on)        integ <= 0;
      else if (ref_sel) integ <= integ - VREF;
      else if (busy)    integ <= integ + vin;
   end

   always @(negedge clk) begin
      cycles <= cycles + 1;
      if (az_on)   az_cnt   <= az_cnt + 1;
      if (ref_sel) sel_cnt  <= sel_cnt + 1;
      if (done)    done_cnt <= done_cnt + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one conversion; poke>0 pulses start again at that cycle
   task automatic convert(input int v, input int poke, output int lat);
      int i0, k, exp_res, exp_ovr, exp_lat, hold;
      vin = v;
      i0 = ((1 << CW) + 2) * v;
      k = (i0 + VREF - 1) / VREF;
      exp_ovr = (k > MAXV) ? 1 : 0;
      if (k > MAXV) k = MAXV;
      exp_res = k;
      exp_lat = ZC + 4 + (1 << CW) + k;
      @(negedge clk);
      az_cnt = 0; sel_cnt = 0; done_cnt = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 5000) begin
         @(negedge clk);
         lat++;
         start = (lat == poke);
      end
      start = 1'b0;
      check("R6 latency", lat, exp_lat);
      check("R6 result", int'(result), exp_res);
      check("R8 overrange flag", int'(overrange), exp_ovr);
      check("R3 auto-zero cycles", az_cnt, ZC);
      check("R5/R6 reference cycles", sel_cnt, k + 1);
      hold = int'(result);
      repeat (20) @(negedge clk);
      check("R7 single done", done_cnt, 1);
      check("R7 result held", int'(result), hold);
      check("R2 no restart", int'(busy), 0);
   endtask

   task automatic t_reset();
      check("R1 az_on", int'(az_on), 0);
      check("R1 ref_sel", int'(ref_sel), 0);
      check("R1 busy", int'(busy), 0);
      check("R1 done", int'(done), 0);
      check("R1 overrange", int'(overrange), 0);
      check("R1 result", int'(result), 0);
   endtask

   task automatic t_no_trip();
      int l;
      vin = 0;
      @(negedge clk);
      sel_cnt = 0; done_cnt = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 2 * (1 << CW) + ZC + 50; i++) @(negedge clk);
      check("R4 still busy", int'(busy), 1);
      check("R4 no reference", sel_cnt, 0);
      check("R4 no done", done_cnt, 0);
      check("R4 az released", int'(az_on), 0);
      do_reset();
      l = 0;
   endtask

   initial begin
      int lat;
      do_reset();
      t_reset();
      convert(1000, 0, lat);
      convert(200, 0, lat_small);
      convert(1500, 0, lat_big);
      check("R9 longer for larger input", int'(lat_big > lat_small), 1);
      convert(1000, 300, lat);        // R2 start ignored while busy
      convert(3000, 0, lat);          // R8 timeout
      convert(500, 0, lat);           // R8 flag clears
      t_no_trip();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule